// File: doc/BRIEF.md
# Multi-Lane Deskew Aligner

This block sits behind the clock-recovery and decoding stages of a two- or four-lane serial receiver. Each lane delivers fixed-width slices of a wide parallel word, with a valid strobe and a marker on the slice that opens a frame. Every lane is recovered from its own embedded clock, so the lanes reach this block with different and drifting latencies. All three per-lane inputs are sampled in one common fast clock. The block buffers each lane in a small FIFO. It starts reading only after every lane has delivered a frame opener, and from then on it pops one slice from every lane in the same cycle. It concatenates the popped slices into the wide word.

No training pattern, command or host action is involved. Alignment comes only from the frame markers each lane already carries. If the buffering is ever exceeded, or the markers popped together disagree, the block throws away everything it holds. It then lowers its lock flag and locks again by itself at the next frame opener on every lane. The lock flag is raised only after a run of clean words.

Top module: `deskew_aligner`

## Requirements
- R1: A word is emitted only in a cycle where every lane FIFO holds at least one slice. One slice is popped from each lane, and lane 0 fills bits [SLICE_W-1:0] with higher lanes at higher bit positions. The word and its valid strobe appear one clock after the pop.
- R2: After reset or a flush, a lane stores nothing until it receives a valid slice with its frame marker set. That marked slice is its first stored entry, so the first word out is made of frame-opening slices.
- R3: A lane that must store a slice while its FIFO is full and no pop happens in that cycle causes a flush. The flush empties all FIFOs, clears the lock flag, and suppresses the word valid strobe on the next clock.
- R4: Once words have started to flow, a cycle in which one lane FIFO is empty while another is full causes a flush.
- R5: If the frame-marker bits of the slices popped together are not all equal, that word is not emitted and a flush follows.
- R6: The lock flag rises on the same clock as the LOCK_WORDS-th (default 8) consecutive word emitted without a flush, and stays low before it.
- R7: Inter-lane skew of up to FIFO_DEPTH-1 fast-clock cycles (default 7) is absorbed: words come out complete, in order, and without a flush.
- R8: After a flush, alignment is rebuilt automatically at the next frame marker on every lane, with no external action.
- R9: While reset is high, the word valid strobe and the lock flag are low on the following clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common fast clock |
| rst | input | 1 | Synchronous active-high reset |
| lane_data | input | NUM_LANES*SLICE_W | Per-lane slices, lane 0 in the low bits |
| lane_valid | input | NUM_LANES | Per-lane slice valid strobe |
| lane_sof | input | NUM_LANES | Per-lane frame-opening marker, qualified by valid |
| word_out | output | WORD_W | Reassembled wide word |
| word_valid | output | 1 | Word strobe, one clock after the pop |
| aligned | output | 1 | Lock flag |

## Verification
Two functions can land in the same clock. A write into a lane FIFO that is already full can coincide with the pop of one slice from every lane. This is a legal steady state and must not be taken for an overflow. The bench provokes it by delaying lane 0 by exactly FIFO_DEPTH-1 cycles, so the other three lanes sit full while popping and writing every cycle. It judges the case by an uninterrupted, in-order word sequence and a raised lock flag at the end. A skew of one more cycle must instead overflow and never lock.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

  // Reason a flush was requested in the current cycle; priority is the order below.
  typedef enum logic [1:0] {
    FAULT_NONE     = 2'd0,
    FAULT_OVERFLOW = 2'd1,
    FAULT_STARVE   = 2'd2,
    FAULT_SLIP     = 2'd3
  } fault_e;

  // Width of a counter that must hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int unsigned SLICE_W = 8,
  parameter int unsigned DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic               wr_valid,
  input  logic               wr_sof,
  input  logic               pop,
  output logic [SLICE_W-1:0] rd_data,
  output logic               rd_sof,
  output logic               empty,
  output logic               full,
  output logic               overflow
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = deskew_pkg::cnt_width(DEPTH);

  // Entry layout: frame marker above the slice.
  logic [SLICE_W:0] mem [DEPTH];
  logic [AW-1:0]    wp;
  logic [AW-1:0]    rp;
  logic [CW-1:0]    cnt;
  logic             armed;
  logic             take;
  logic             wr_en;
  logic             rd_en;

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  // A slice is kept once the lane has seen a frame opener since the last flush.
  assign take     = wr_valid & (armed | wr_sof);
  assign overflow = take & full & ~pop;
  assign wr_en    = take & ~overflow & ~flush;
  assign rd_en    = pop & ~empty & ~flush;

  // Storage without reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= {wr_sof, wr_data};
  end

  assign rd_data = mem[rp][SLICE_W-1:0];
  assign rd_sof  = mem[rp][SLICE_W];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + AW'(1);
      if (rd_en) rp <= rp + AW'(1);
      cnt <= cnt + CW'(wr_en) - CW'(rd_en);
      if (wr_en) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
  import deskew_pkg::*;
#(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned LOCK_WORDS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LANES-1:0] lane_empty,
  input  logic [NUM_LANES-1:0] lane_full,
  input  logic [NUM_LANES-1:0] lane_ovf,
  input  logic [NUM_LANES-1:0] lane_rd_sof,
  output logic                 pop_ok,
  output logic                 flush,
  output logic                 fire,
  output logic                 aligned
);
  localparam int unsigned LW = cnt_width(LOCK_WORDS);

  logic          started;
  logic [LW-1:0] good_cnt;
  fault_e        cause;

  // Every lane holds a slice: pop all of them together.
  assign pop_ok = ~|lane_empty;

  always_comb begin
    cause = FAULT_NONE;
    if (|lane_ovf)
      cause = FAULT_OVERFLOW;
    else if (started && (|lane_empty) && (|lane_full))
      cause = FAULT_STARVE;
    else if (pop_ok && (|lane_rd_sof) && !(&lane_rd_sof))
      cause = FAULT_SLIP;
  end

  assign flush = (cause != FAULT_NONE);
  assign fire  = pop_ok & ~flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      started  <= 1'b0;
      good_cnt <= '0;
      aligned  <= 1'b0;
    end else if (fire) begin
      started <= 1'b1;
      if (good_cnt != LW'(LOCK_WORDS)) good_cnt <= good_cnt + LW'(1);
      if (good_cnt == LW'(LOCK_WORDS - 1)) aligned <= 1'b1;
    end
  end

endmodule

// File: rtl/deskew_aligner.sv
module deskew_aligner #(
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned LOCK_WORDS = 8,
  localparam int unsigned SLICE_W   = WORD_W / NUM_LANES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_LANES*SLICE_W-1:0] lane_data,
  input  logic [NUM_LANES-1:0]         lane_valid,
  input  logic [NUM_LANES-1:0]         lane_sof,
  output logic [WORD_W-1:0]            word_out,
  output logic                         word_valid,
  output logic                         aligned
);
  logic [NUM_LANES-1:0][SLICE_W-1:0] rd_slices;
  logic [NUM_LANES-1:0]              lane_rd_sof;
  logic [NUM_LANES-1:0]              lane_empty;
  logic [NUM_LANES-1:0]              lane_full;
  logic [NUM_LANES-1:0]              lane_ovf;
  logic                              pop_ok;
  logic                              flush;
  logic                              fire;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    lane_fifo #(
      .SLICE_W (SLICE_W),
      .DEPTH   (FIFO_DEPTH)
    ) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .wr_data  (lane_data[g*SLICE_W +: SLICE_W]),
      .wr_valid (lane_valid[g]),
      .wr_sof   (lane_sof[g]),
      .pop      (pop_ok),
      .rd_data  (rd_slices[g]),
      .rd_sof   (lane_rd_sof[g]),
      .empty    (lane_empty[g]),
      .full     (lane_full[g]),
      .overflow (lane_ovf[g])
    );
  end

  align_ctrl #(
    .NUM_LANES  (NUM_LANES),
    .LOCK_WORDS (LOCK_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .lane_empty  (lane_empty),
    .lane_full   (lane_full),
    .lane_ovf    (lane_ovf),
    .lane_rd_sof (lane_rd_sof),
    .pop_ok      (pop_ok),
    .flush       (flush),
    .fire        (fire),
    .aligned     (aligned)
  );

  // Packed lane array puts lane 0 in the low bits of the word.
  always_ff @(posedge clk) begin
    if (rst) begin
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= fire;
      if (fire) word_out <= WORD_W'(rd_slices);
    end
  end

endmodule

// File: rtl/deskew_aligner_chk.sv
module deskew_aligner_chk #(
  parameter int unsigned NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 word_valid,
  input logic                 aligned,
  input logic                 flush,
  input logic                 pop_ok,
  input logic [NUM_LANES-1:0] lane_empty,
  input logic [NUM_LANES-1:0] lane_full,
  input logic [NUM_LANES-1:0] lane_rd_sof
);

  p_reset_quiet_r9: assert property (@(posedge clk)
    rst |=> (!word_valid && !aligned));

  p_flush_clears_r3: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!aligned && !word_valid));

  p_starve_unlocks_r4: assert property (@(posedge clk) disable iff (rst)
    (aligned && (|lane_empty) && (|lane_full)) |=> !aligned);

  p_slip_blocks_word_r5: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && (|lane_rd_sof) && !(&lane_rd_sof)) |=> !word_valid);

  p_lock_with_word_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(aligned) |-> word_valid);

endmodule

bind deskew_aligner deskew_aligner_chk #(.NUM_LANES(NUM_LANES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .word_valid  (word_valid),
  .aligned     (aligned),
  .flush       (flush),
  .pop_ok      (pop_ok),
  .lane_empty  (lane_empty),
  .lane_full   (lane_full),
  .lane_rd_sof (lane_rd_sof)
);

// File: tb/sim_deskew_aligner.sv
module sim_deskew_aligner;
  localparam int NL    = 4;
  localparam int SW    = 8;
  localparam int FRAME = 16;
  localparam int NCYC  = 200;
  localparam int NVEC  = 8;

  // d0..d3 skew, gap lane, gap start, gap len, gap mode (0 none,1 stall,2 skip),
  // start index, clean, expected final lock, min words, max words
  localparam int VEC [NVEC][13] = '{
    '{0, 0, 0, 0, 0,  0, 0, 0, 0, 1, 1, 150, 200},
    '{0, 1, 2, 3, 0,  0, 0, 0, 0, 1, 1, 150, 200},
    '{3, 0, 5, 1, 0,  0, 0, 0, 0, 1, 1, 150, 200},
    '{7, 0, 0, 0, 0,  0, 0, 0, 0, 1, 1, 150, 200},
    '{8, 0, 0, 0, 0,  0, 0, 0, 0, 1, 0,   0,   0},
    '{0, 0, 0, 0, 2, 60, 8, 1, 0, 1, 0,  40,  70},
    '{0, 0, 0, 0, 1, 60, 3, 2, 0, 0, 1, 100, 200},
    '{0, 2, 1, 0, 0,  0, 0, 0, 5, 1, 1, 150, 200}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NL*SW-1:0]  lane_data = '0;
  logic [NL-1:0]     lane_valid = '0;
  logic [NL-1:0]     lane_sof = '0;
  logic [NL*SW-1:0]  word_out;
  logic              word_valid;
  logic              aligned;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  int  idx [NL];
  string tag [NVEC] = '{"R1", "R7", "R7", "R7", "R3", "R4", "R5", "R2"};

  always #2 clk = ~clk;

  deskew_aligner u0 (
    .clk        (clk),
    .rst        (rst),
    .lane_data  (lane_data),
    .lane_valid (lane_valid),
    .lane_sof   (lane_sof),
    .word_out   (word_out),
    .word_valid (word_valid),
    .aligned    (aligned)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int v);
    int  words = 0;
    bit  have_prev = 1'b0;
    int  prev_k = 0;
    bit  last_cons = 1'b0;
    rst = 1'b1;
    lane_valid = '0;
    lane_sof = '0;
    lane_data = '0;
    for (int i = 0; i < NL; i++) idx[i] = VEC[v][8];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int t = 0; t < NCYC; t++) begin
      @(negedge clk);
      // sample the result of the previous edge
      if (word_valid) begin
        int  k0;
        bit  cons;
        words++;
        k0 = int'(word_out[7:2]);
        cons = 1'b1;
        for (int i = 0; i < NL; i++) begin
          if (int'(word_out[i*SW+2 +: 6]) != k0) cons = 1'b0;
          if (int'(word_out[i*SW +: 2]) != i) cons = 1'b0;
        end
        last_cons = cons;
        if (VEC[v][9] != 0) begin
          chk(cons, "R1 lane slices of one word", int'(cons), 1);
          if (!have_prev)
            chk((k0 % FRAME) == 0, "R2 first word opens a frame", k0, (k0 / FRAME) * FRAME);
          else
            chk(k0 == ((prev_k + 1) % 64), "R7 word order under skew", k0, (prev_k + 1) % 64);
          if (words == 7) chk(!aligned, "R6 lock before 8th word", int'(aligned), 0);
          if (words == 8) chk(aligned, "R6 lock with 8th word", int'(aligned), 1);
        end
        have_prev = 1'b1;
        prev_k = k0;
      end
      // drive cycle t
      for (int i = 0; i < NL; i++) begin
        bit gap;
        gap = (VEC[v][7] != 0) && (i == VEC[v][4]) &&
              (t >= VEC[v][5]) && (t < VEC[v][5] + VEC[v][6]);
        if (t < VEC[v][i] || gap) begin
          lane_valid[i] = 1'b0;
          lane_sof[i] = 1'b0;
          if (gap && VEC[v][7] == 2) idx[i]++;
        end else begin
          lane_valid[i] = 1'b1;
          lane_sof[i] = ((idx[i] % FRAME) == 0);
          lane_data[i*SW +: SW] = {6'(idx[i]), 2'(i)};
          idx[i]++;
        end
      end
    end
    chk(aligned == VEC[v][10][0], {tag[v], " final lock"}, int'(aligned), VEC[v][10]);
    chk(words >= VEC[v][11] && words <= VEC[v][12], {tag[v], " word count"}, words, VEC[v][11]);
    if (VEC[v][10] != 0)
      chk(last_cons, "R8 last word consistent after recovery", int'(last_cons), 1);
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!word_valid && !aligned, "R9 reset state", int'(word_valid) + int'(aligned), 0);
    for (int v = 0; v < NVEC; v++) run_vec(v);
    // R9: reset while locked (last vector ends locked)
    rst = 1'b1;
    @(negedge clk);
    chk(!word_valid && !aligned, "R9 reset while locked", int'(word_valid) + int'(aligned), 0);
    rst = 1'b0;
    lane_valid = '0;
    @(negedge clk);
    chk(!aligned, "R9 no lock after reset", int'(aligned), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule